// File: doc/BRIEF.md
# Period Timer with Compare-Event Restart

This block is a 16-bit up-counting timer with a 16-bit compare register beside it. Software loads either register one byte at a time. The timer advances by one on each cycle where the run state machine is in RUNNING and the prescaled count-enable input is high. When the timer rolls over from all ones to zero it raises a sticky overflow flag.

The compare unit checks the timer against the compare register once per count step, using the value the timer holds before that step. In the compare modes (mode field 4'b10xx), a match sets a sticky match flag. In the restart mode (4'b1011), a match also clears the timer in place of that step's increment, so the compare register sets the period. It also emits a one-cycle conversion-start strobe toward an external converter whenever the converter-enable input is high. Two things block the restart: the asynchronous counter source, and a software write to the timer in the same cycle, which wins.

The run state machine has two states:
- STOPPED: the state after reset.
- RUNNING.

It has two transitions, both taken at a clock edge:
- START: STOPPED to RUNNING, when the timer-on bit is sampled high.
- HALT: RUNNING to STOPPED, when the timer-on bit is sampled low.

Top module: `tce_timer_top`

## Requirements
- R1: After a synchronous reset, the following are all zero: the timer, the compare register, the overflow flag, the match flag and the start strobe. The run state is STOPPED.
- R2: The timer increments by one at an edge only if the run state is RUNNING and cnt_en is high at that edge. The run state becomes RUNNING at the edge where tmr_on is sampled high (START), and STOPPED at the edge where it is sampled low (HALT). In STOPPED the timer holds its value unless it is written.
- R3: Byte write-enable bit 0 selects bits 7:0 and bit 1 selects bits 15:8, for both the timer and the compare register. A write replaces only the selected byte with wr_byte. In a write cycle the timer does not increment.
- R4: A count step taken at 16'hFFFF gives 16'h0000 and sets ovf_flag. The flag stays set until ovf_clr is high at an edge. If a new overflow arrives in that same cycle, the set wins.
- R5: With cmp_mode[3:2] = 2'b10, a count step taken while the timer equals the compare register sets match_flag. The flag stays set until match_clr. Any other cmp_mode value never sets it.
- R6: With cmp_mode = 4'b1011 and src_mode not 2'b10, a matching step loads 0 instead of incrementing. The timer then cycles through 0 up to the compare value, a period of compare+1 steps.
- R7: In cmp_mode 4'b1011, a matching step makes adc_start high for exactly the one cycle after that edge, but only if adc_en is high. Otherwise adc_start stays low.
- R8: A restart caused by a compare event never sets ovf_flag, including when the compare value is 16'hFFFF.
- R9: With src_mode = 2'b10 (asynchronous counter), a match in mode 4'b1011 does not restart the timer; it increments as normal. The other source codes are 2'b00 (timer) and 2'b01 (synchronized counter), and 2'b11 is treated like 2'b01.
- R10: A timer byte write in the same cycle as a restart loads the written byte. The restart is discarded, and the bytes that were not written keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Prescaled count enable |
| tmr_on | input | 1 | Timer run request |
| src_mode | input | 2 | Count source: 00 timer, 01 synchronized, 10 asynchronous |
| cmp_mode | input | 4 | Compare mode; 10xx compare, 1011 restart with conversion start |
| tmr_byte_we | input | 2 | Timer byte write enables |
| cmp_byte_we | input | 2 | Compare register byte write enables |
| wr_byte | input | 8 | Write data byte |
| adc_en | input | 1 | Converter enabled |
| ovf_clr | input | 1 | Clears the overflow flag |
| match_clr | input | 1 | Clears the match flag |
| tmr_value | output | 16 | Current timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| match_flag | output | 1 | Sticky compare-match flag |
| adc_start | output | 1 | One-cycle conversion-start strobe |

## Verification
The bench sets a compare value of 16'hFFFF in restart mode, so the match and the rollover coincide. A design that let the wrap path run there would raise the overflow flag, and a design that let the restart through would lose the period. The bench also checks the asynchronous source, where a design that ignored the source would restart the timer. It checks a byte write that collides with a restart, where a design with the wrong priority would read zero instead of the written byte. It measures a full period and checks that the strobe is a single cycle that disappears when the converter is disabled. A one-off period or a strobe held for two cycles would show up as a wrong count or a second high sample.

// File: rtl/tce_pkg.sv
package tce_pkg;
    typedef enum logic [1:0] {
        SRC_TIMER = 2'b00,
        SRC_SYNC  = 2'b01,
        SRC_ASYNC = 2'b10,
        SRC_RSVD  = 2'b11
    } src_e;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_e;

    localparam logic [3:0] CMP_RESTART = 4'b1011;
    localparam logic [1:0] CMP_FAMILY  = 2'b10;
endpackage

// File: rtl/tce_byte_reg.sv
module tce_byte_reg #(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = REG_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     byte_we,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [REG_W-1:0]  q
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                q[b*BYTE_W +: BYTE_W] <= '0;
            end else if (byte_we[b]) begin
                q[b*BYTE_W +: BYTE_W] <= wr_byte;
            end
        end
    end
endmodule

// File: rtl/tce_counter.sv
module tce_counter #(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = REG_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     byte_we,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              step,
    input  logic              evt_clear,
    output logic [REG_W-1:0]  q,
    output logic              wrap
);
    logic             any_we;
    logic [REG_W-1:0] nxt;

    assign any_we = |byte_we;
    // Wrap only on a plain count step: writes and restarts override it.
    assign wrap   = step && !any_we && !evt_clear && (&q);

    always_comb begin
        nxt = q;
        if (any_we) begin
            for (int b = 0; b < NB; b++) begin
                if (byte_we[b]) nxt[b*BYTE_W +: BYTE_W] = wr_byte;
            end
        end else if (evt_clear) begin
            nxt = '0;
        end else if (step) begin
            nxt = q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    // R10: a written byte survives a coincident restart
    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (evt_clear && byte_we[0]) |=> q[BYTE_W-1:0] == $past(wr_byte));
endmodule

// File: rtl/tce_cmp_unit.sv
module tce_cmp_unit
    import tce_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] tmr,
    input  logic [REG_W-1:0] cmp,
    input  logic             step,
    input  logic [3:0]       cmp_mode,
    input  logic [1:0]       src_mode,
    output logic             hit,
    output logic             evt,
    output logic             evt_clear
);
    logic equal;

    assign equal     = (tmr == cmp);
    assign hit       = step && equal && (cmp_mode[3:2] == CMP_FAMILY);
    assign evt       = hit && (cmp_mode == CMP_RESTART);
    assign evt_clear = evt && (src_e'(src_mode) != SRC_ASYNC);
endmodule

// File: rtl/tce_timer_top.sv
module tce_timer_top
    import tce_pkg::*;
#(
    parameter int TMR_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = TMR_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              tmr_on,
    input  logic [1:0]        src_mode,
    input  logic [3:0]        cmp_mode,
    input  logic [NB-1:0]     tmr_byte_we,
    input  logic [NB-1:0]     cmp_byte_we,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              adc_en,
    input  logic              ovf_clr,
    input  logic              match_clr,
    output logic [TMR_W-1:0]  tmr_value,
    output logic              ovf_flag,
    output logic              match_flag,
    output logic              adc_start
);
    run_e             state_q, state_d;
    logic             step;
    logic             wrap, hit, evt, evt_clear;
    logic [TMR_W-1:0] cmp_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STOPPED;
        else     state_q <= state_d;
    end

    // Transitions START and HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (tmr_on)  state_d = ST_RUNNING;
            ST_RUNNING: if (!tmr_on) state_d = ST_STOPPED;
            default:                 state_d = ST_STOPPED;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        step = 1'b0;
        unique case (state_q)
            ST_STOPPED: step = 1'b0;
            ST_RUNNING: step = cnt_en;
            default:    step = 1'b0;
        endcase
    end

    tce_byte_reg #(.REG_W(TMR_W), .BYTE_W(BYTE_W)) i_cmp_reg (
        .clk     (clk),
        .rst     (rst),
        .byte_we (cmp_byte_we),
        .wr_byte (wr_byte),
        .q       (cmp_q)
    );

    tce_cmp_unit #(.REG_W(TMR_W)) i_cmp_unit (
        .tmr       (tmr_value),
        .cmp       (cmp_q),
        .step      (step),
        .cmp_mode  (cmp_mode),
        .src_mode  (src_mode),
        .hit       (hit),
        .evt       (evt),
        .evt_clear (evt_clear)
    );

    tce_counter #(.REG_W(TMR_W), .BYTE_W(BYTE_W)) i_counter (
        .clk       (clk),
        .rst       (rst),
        .byte_we   (tmr_byte_we),
        .wr_byte   (wr_byte),
        .step      (step),
        .evt_clear (evt_clear),
        .q         (tmr_value),
        .wrap      (wrap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag   <= 1'b0;
            match_flag <= 1'b0;
            adc_start  <= 1'b0;
        end else begin
            if (wrap)         ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
            if (hit)            match_flag <= 1'b1;
            else if (match_clr) match_flag <= 1'b0;
            adc_start <= evt && adc_en;
        end
    end

    // R2: a stopped timer with no write holds its value
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOPPED && tmr_byte_we == '0) |=> tmr_value == $past(tmr_value));

    // R5: match flag is sticky until cleared
    p_match_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (match_flag && !match_clr) |=> match_flag);

    // R7: strobe only follows an enabled converter
    p_adc_gate_r7: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> $past(adc_en));

    // R8: a restart never raises the overflow flag
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_clear && !ovf_flag) |=> !ovf_flag);

    // R9: asynchronous source keeps counting through a restart match
    p_async_counts_r9: assert property (@(posedge clk) disable iff (rst)
        (evt && src_e'(src_mode) == SRC_ASYNC && tmr_byte_we == '0)
        |=> tmr_value == $past(tmr_value) + 16'd1);
endmodule

// File: tb/test_tce_timer_top.sv
module test_tce_timer_top;
    logic        clk = 1'b0;
    logic        rst, cnt_en, tmr_on, adc_en, ovf_clr, match_clr;
    logic [1:0]  src_mode, tmr_byte_we, cmp_byte_we;
    logic [3:0]  cmp_mode;
    logic [7:0]  wr_byte;
    logic [15:0] tmr_value;
    logic        ovf_flag, match_flag, adc_start;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tce_timer_top i_tce_timer_top (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .tmr_on(tmr_on),
        .src_mode(src_mode), .cmp_mode(cmp_mode), .tmr_byte_we(tmr_byte_we),
        .cmp_byte_we(cmp_byte_we), .wr_byte(wr_byte), .adc_en(adc_en),
        .ovf_clr(ovf_clr), .match_clr(match_clr), .tmr_value(tmr_value),
        .ovf_flag(ovf_flag), .match_flag(match_flag), .adc_start(adc_start)
    );

    // vector: {lo_we, hi_we, data[7:0], cnt_en, exp_tmr[15:0]}
    localparam logic [26:0] VEC [8] = '{
        {1'b0, 1'b0, 8'h00, 1'b1, 16'h0001},
        {1'b0, 1'b0, 8'h00, 1'b1, 16'h0002},
        {1'b0, 1'b0, 8'h00, 1'b0, 16'h0002},
        {1'b1, 1'b0, 8'h34, 1'b1, 16'h0034},
        {1'b0, 1'b1, 8'h12, 1'b1, 16'h1234},
        {1'b0, 1'b0, 8'h00, 1'b1, 16'h1235},
        {1'b1, 1'b0, 8'hFF, 1'b0, 16'h12FF},
        {1'b0, 1'b0, 8'h00, 1'b1, 16'h1300}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        tmr_byte_we = 2'b00; cmp_byte_we = 2'b00;
        ovf_clr = 1'b0; match_clr = 1'b0; cnt_en = 1'b0;
    endtask

    task automatic set_tmr(input logic [15:0] v);
        tmr_byte_we = 2'b01; wr_byte = v[7:0];  tick();
        tmr_byte_we = 2'b10; wr_byte = v[15:8]; tick();
    endtask

    task automatic set_cmp(input logic [15:0] v);
        cmp_byte_we = 2'b01; wr_byte = v[7:0];  tick();
        cmp_byte_we = 2'b10; wr_byte = v[15:8]; tick();
    endtask

    task automatic step_once();
        cnt_en = 1'b1; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cnt_en = 0; tmr_on = 0; adc_en = 0; ovf_clr = 0; match_clr = 0;
        src_mode = 2'b00; cmp_mode = 4'b0000; tmr_byte_we = 0; cmp_byte_we = 0; wr_byte = 0;
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        chk("R1 tmr", tmr_value, 0);
        chk("R1 flags", {ovf_flag, match_flag, adc_start}, 0);

        // R2: stopped state ignores cnt_en
        step_once();
        chk("R2 stopped hold", tmr_value, 0);
        tmr_on = 1'b1; tick();   // START
        chk("R2 idle after start", tmr_value, 0);

        // R2/R3 vector table
        for (int i = 0; i < 8; i++) begin
            tmr_byte_we = {VEC[i][25], VEC[i][26]};
            wr_byte     = VEC[i][24:17];
            cnt_en      = VEC[i][16];
            tick();
            chk("R2/R3 vector", tmr_value, VEC[i][15:0]);
        end
        set_cmp(16'hA5C3);
        chk("R1/R3 tmr untouched by cmp write", tmr_value, 16'h1300);

        // R4 overflow
        set_tmr(16'hFFFE);
        step_once(); chk("R4 pre", {ovf_flag, tmr_value}, {1'b0, 16'hFFFF});
        step_once(); chk("R4 wrap", {ovf_flag, tmr_value}, {1'b1, 16'h0000});
        tick();      chk("R4 sticky", ovf_flag, 1);
        ovf_clr = 1; tick(); chk("R4 clear", ovf_flag, 0);
        set_tmr(16'hFFFF);
        ovf_clr = 1; step_once(); chk("R4 set beats clear", ovf_flag, 1);
        ovf_clr = 1; tick();

        // R5 compare match
        cmp_mode = 4'b1000; set_cmp(16'h0005); set_tmr(16'h0004);
        match_clr = 1; tick();
        step_once(); chk("R5 no match at 4", match_flag, 0);
        step_once(); chk("R5 match at 5", {match_flag, tmr_value}, {1'b1, 16'h0006});
        chk("R7 no strobe in plain compare", adc_start, 0);
        tick(); chk("R5 sticky", match_flag, 1);
        match_clr = 1; tick(); chk("R5 clear", match_flag, 0);
        cmp_mode = 4'b0000; set_tmr(16'h0005);
        step_once(); chk("R5 mode off", match_flag, 0);

        // R6/R7 restart mode
        cmp_mode = 4'b1011; adc_en = 1; set_tmr(16'h0004);
        step_once(); chk("R6 at cmp", tmr_value, 16'h0005);
        step_once(); chk("R6 restart", tmr_value, 16'h0000);
        chk("R7 strobe", adc_start, 1);
        chk("R5 flag in restart mode", match_flag, 1);
        step_once(); chk("R7 strobe one cycle", {adc_start, tmr_value}, {1'b0, 16'h0001});
        for (int k = 0; k < 5; k++) step_once();
        chk("R6 period 6 steps", tmr_value, 16'h0000);
        adc_en = 0; set_tmr(16'h0005);
        step_once(); chk("R7 no strobe disabled", {adc_start, tmr_value}, {1'b0, 16'h0000});

        // R8 restart at all ones
        set_cmp(16'hFFFF); set_tmr(16'hFFFE); ovf_clr = 1; tick();
        step_once(); step_once();
        chk("R8 no overflow", {ovf_flag, tmr_value}, {1'b0, 16'h0000});

        // R9 asynchronous source
        set_cmp(16'h0005); set_tmr(16'h0005); src_mode = 2'b10;
        step_once(); chk("R9 async counts on", tmr_value, 16'h0006);
        src_mode = 2'b00;

        // R10 write beats restart
        set_tmr(16'h0005);
        tmr_byte_we = 2'b01; wr_byte = 8'h20; cnt_en = 1; tick();
        chk("R10 write wins", tmr_value, 16'h0020);

        // HALT
        tmr_on = 0; tick();
        step_once(); chk("R2 halted", tmr_value, 16'h0020);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule